// File: doc/BRIEF.md
# Condition Code Register with Per-Class Flag Update

This block holds the 8-bit condition code register of a small 8-bit accumulator processor. Every cycle, the surrounding datapath presents the ALU result together with the operand sign bits, the carry or borrow out of the top bit, the carry out of bit 3, the bit lost by a shift, and a status bit from the multiply/divide unit. An instruction-class code tells the block which of the five status flags (carry, overflow, zero, negative, half-carry) that operation is allowed to change. Flags the class does not own keep their old values.

The register also holds three control bits: two interrupt mask bits and a stop-disable bit. No flag update ever touches them. They change only through the full-register write port, which serves transfer-to-register and pull-from-stack operations. A rotate reads the current carry from the register output and returns it to the datapath, which lets multi-word shifts chain through carry.

Top module: `ccr_unit`

## Requirements
- R1: While rst_n is low at a rising edge, the register loads 0xD0. The bit layout from bit 7 to bit 0 is S (stop-disable), X (non-maskable mask), H, I (interrupt mask), N, Z, V, C, so after reset S, X and I are set and every status flag is clear.
- R2: When wr_en is high at a rising edge, ccr_q takes wr_data on that edge. This write wins over any flag update presented in the same cycle.
- R3: Bits 7, 6 and 4 change only through a full write. No class code changes them.
- R4: Class code 0 (push, pull, index add, transfer/exchange), class codes 11 to 15, and any cycle with op_valid low all leave the whole register unchanged.
- R5: Class 1 (8-bit add) sets the flags as follows: C from alu_carry, H from alu_half, V to signed overflow of the addition (both operand signs equal and the result sign different), N to alu_res[7], and Z high exactly when alu_res[7:0] is zero.
- R6: Class 2 (8-bit subtract) and class 3 (8-bit compare, difference discarded) set the flags as follows: C from alu_carry (the borrow), V to subtraction overflow (operand signs differ and the result sign differs from the first operand), and N and Z from alu_res[7:0]. H is unchanged.
- R7: Class 4 (logic) and class 5 (load/store) set N and Z from alu_res[7:0] and clear V. C and H are unchanged.
- R8: Class 6 (shift/rotate) sets C to shift_out, sets N and Z from alu_res[7:0], and sets V to the new N XOR the new C. H is unchanged.
- R9: Class 7 (multiply/divide) sets C from md_status and sets Z from all 16 bits of alu_res. N, V and H are unchanged.
- R10: Class 8 (16-bit index increment/decrement) writes only Z, which is high exactly when alu_res[15:0] is zero.
- R11: Class 9 (16-bit add) and class 10 (16-bit subtract) set C from alu_carry, set V with the add or subtract overflow rule applied to the bit-15 signs, and take N from alu_res[15] and Z from all 16 bits. H is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Apply the flag update of op_class this cycle |
| op_class | input | 4 | Instruction-class code |
| alu_res | input | 16 | ALU result; 8-bit classes use bits 7:0 |
| src_a_msb | input | 1 | Sign bit of the first operand (bit 7 or bit 15) |
| src_b_msb | input | 1 | Sign bit of the second operand |
| alu_carry | input | 1 | Carry out on add, borrow on subtract |
| alu_half | input | 1 | Carry out of bit 3 |
| shift_out | input | 1 | Bit shifted out by a shift or rotate |
| md_status | input | 1 | Error/status bit from multiply or divide |
| wr_en | input | 1 | Full-register write strobe |
| wr_data | input | 8 | Full-register write value |
| ccr_q | output | 8 | Register contents |

## Verification
Every result arrives one rising edge after its inputs are presented. A full write, a class update and a reset each show up on ccr_q just after that edge. The bench drives each stimulus on the falling edge and compares ccr_q 1 ns after the next rising edge. That check happens before the following falling edge changes the inputs, so each comparison sees exactly one update. The expected register is carried forward from check to check, which exposes any flag that a class changes when it should not.

// File: rtl/ccr_pkg.sv
// Package: shared encodings for the condition code unit.
// Assumes an 8-bit register and five status flags held in a fixed bit layout.
package ccr_pkg;

    localparam int CCR_W  = 8;
    localparam int NFLAG  = 5;

    // Register bit positions (S X H I N Z V C from bit 7 down)
    localparam int POS_C = 0;
    localparam int POS_V = 1;
    localparam int POS_Z = 2;
    localparam int POS_N = 3;
    localparam int POS_I = 4;
    localparam int POS_H = 5;
    localparam int POS_X = 6;
    localparam int POS_S = 7;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

    // Status vector indices
    localparam int SI_C = 0;
    localparam int SI_V = 1;
    localparam int SI_Z = 2;
    localparam int SI_N = 3;
    localparam int SI_H = 4;

    typedef logic [NFLAG-1:0] status_t;

    typedef enum logic [3:0] {
        CLS_PASS   = 4'd0,
        CLS_ADD8   = 4'd1,
        CLS_SUB8   = 4'd2,
        CLS_CMP8   = 4'd3,
        CLS_LOGIC  = 4'd4,
        CLS_LDST   = 4'd5,
        CLS_SHIFT  = 4'd6,
        CLS_MULDIV = 4'd7,
        CLS_IDX16  = 4'd8,
        CLS_ADD16  = 4'd9,
        CLS_SUB16  = 4'd10
    } op_class_e;

    // Map a status index to its register bit position
    function automatic int stat_pos(input int idx);
        case (idx)
            SI_C:    return POS_C;
            SI_V:    return POS_V;
            SI_Z:    return POS_Z;
            SI_N:    return POS_N;
            default: return POS_H;
        endcase
    endfunction

    // Which status flags a class is allowed to write
    function automatic status_t write_mask(input logic [3:0] cls);
        status_t m;
        m = '0;
        case (cls)
            CLS_ADD8:                    m = 5'b11111;
            CLS_SUB8, CLS_CMP8,
            CLS_SHIFT,
            CLS_ADD16, CLS_SUB16:        begin m[SI_C] = 1'b1; m[SI_V] = 1'b1; m[SI_Z] = 1'b1; m[SI_N] = 1'b1; end
            CLS_LOGIC, CLS_LDST:         begin m[SI_V] = 1'b1; m[SI_Z] = 1'b1; m[SI_N] = 1'b1; end
            CLS_MULDIV:                  begin m[SI_C] = 1'b1; m[SI_Z] = 1'b1; end
            CLS_IDX16:                   m[SI_Z] = 1'b1;
            default:                     m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ccr_flag_calc.sv
// Module: ccr_flag_calc
// Computes candidate values of all five status flags for the presented class.
// Assumes: purely combinational; flags the class does not own are don't-care
// here and are discarded by the merge stage.
module ccr_flag_calc
    import ccr_pkg::*;
#(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic [3:0]        cls,
    input  logic [WIDE_W-1:0] res,
    input  logic              a_msb,
    input  logic              b_msb,
    input  logic              carry,
    input  logic              half,
    input  logic              sh_out,
    input  logic              md_stat,
    output status_t           cand
);
    localparam int NMSB = NARROW_W - 1;
    localparam int WMSB = WIDE_W - 1;

    logic n8, n16, z8, z16;
    logic v_add8, v_sub8, v_add16, v_sub16;

    // Sign and zero of both result widths
    always_comb begin
        n8  = res[NMSB];
        n16 = res[WMSB];
        z8  = (res[NMSB:0] == '0);
        z16 = (res == '0);
    end

    // Two's-complement overflow for add and subtract at both widths
    always_comb begin
        v_add8  = ( a_msb &  b_msb & ~n8 ) | (~a_msb & ~b_msb &  n8 );
        v_sub8  = ( a_msb & ~b_msb & ~n8 ) | (~a_msb &  b_msb &  n8 );
        v_add16 = ( a_msb &  b_msb & ~n16) | (~a_msb & ~b_msb &  n16);
        v_sub16 = ( a_msb & ~b_msb & ~n16) | (~a_msb &  b_msb &  n16);
    end

    // Per-class selection of candidate flag values
    always_comb begin
        cand = '0;
        case (cls)
            CLS_ADD8: begin
                cand[SI_C] = carry;  cand[SI_V] = v_add8;
                cand[SI_Z] = z8;     cand[SI_N] = n8;   cand[SI_H] = half;
            end
            CLS_SUB8, CLS_CMP8: begin
                cand[SI_C] = carry;  cand[SI_V] = v_sub8;
                cand[SI_Z] = z8;     cand[SI_N] = n8;
            end
            CLS_LOGIC, CLS_LDST: begin
                cand[SI_V] = 1'b0;   cand[SI_Z] = z8;   cand[SI_N] = n8;
            end
            CLS_SHIFT: begin
                cand[SI_C] = sh_out; cand[SI_V] = n8 ^ sh_out;
                cand[SI_Z] = z8;     cand[SI_N] = n8;
            end
            CLS_MULDIV: begin
                cand[SI_C] = md_stat; cand[SI_Z] = z16;
            end
            CLS_IDX16: begin
                cand[SI_Z] = z16;
            end
            CLS_ADD16: begin
                cand[SI_C] = carry;  cand[SI_V] = v_add16;
                cand[SI_Z] = z16;    cand[SI_N] = n16;
            end
            CLS_SUB16: begin
                cand[SI_C] = carry;  cand[SI_V] = v_sub16;
                cand[SI_Z] = z16;    cand[SI_N] = n16;
            end
            default: cand = '0;
        endcase
    end

endmodule

// File: rtl/ccr_status_merge.sv
// Module: ccr_status_merge
// Combines candidate flags with the held flags under the class write mask.
// Assumes: the held status is extracted from the register by bit position.
module ccr_status_merge
    import ccr_pkg::*;
(
    input  logic [CCR_W-1:0] ccr_cur,
    input  logic [3:0]       cls,
    input  status_t          cand,
    output status_t          merged
);
    status_t mask;

    // Look up the writable flags for this class
    always_comb mask = write_mask(cls);

    // One selector per flag: take the candidate only where the mask allows
    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        localparam int P = stat_pos(gi);
        assign merged[gi] = mask[gi] ? cand[gi] : ccr_cur[P];
    end

endmodule

// File: rtl/ccr_store.sv
// Module: ccr_store
// Holds the 8-bit register; applies reset, full write or merged flag update.
// Assumes: synchronous active-low reset; a full write has priority over updates.
module ccr_store
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CCR_W-1:0] wr_data,
    input  logic             upd_en,
    input  status_t          merged,
    output logic [CCR_W-1:0] ccr_q
);
    logic [CCR_W-1:0] upd_val;

    // Overlay merged status flags; control bits pass through untouched
    always_comb begin
        upd_val        = ccr_q;
        upd_val[POS_C] = merged[SI_C];
        upd_val[POS_V] = merged[SI_V];
        upd_val[POS_Z] = merged[SI_Z];
        upd_val[POS_N] = merged[SI_N];
        upd_val[POS_H] = merged[SI_H];
    end

    // Register update with reset, write and update priority
    always_ff @(posedge clk) begin
        if (!rst_n)       ccr_q <= CCR_RESET;
        else if (wr_en)   ccr_q <= wr_data;
        else if (upd_en)  ccr_q <= upd_val;
    end

endmodule

// File: rtl/ccr_unit.sv
// Module: ccr_unit (top)
// Condition code register with per-class selective status flag update.
// Assumes: ALU outputs are valid in the cycle op_valid is high; results
// appear on ccr_q after the next rising edge.
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_class,
    input  logic [WIDE_W-1:0] alu_res,
    input  logic              src_a_msb,
    input  logic              src_b_msb,
    input  logic              alu_carry,
    input  logic              alu_half,
    input  logic              shift_out,
    input  logic              md_status,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        ccr_q
);
    status_t cand;
    status_t merged;

    ccr_flag_calc #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_calc (
        .cls     (op_class),
        .res     (alu_res),
        .a_msb   (src_a_msb),
        .b_msb   (src_b_msb),
        .carry   (alu_carry),
        .half    (alu_half),
        .sh_out  (shift_out),
        .md_stat (md_status),
        .cand    (cand)
    );

    ccr_status_merge u_merge (
        .ccr_cur (ccr_q),
        .cls     (op_class),
        .cand    (cand),
        .merged  (merged)
    );

    ccr_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .upd_en  (op_valid),
        .merged  (merged),
        .ccr_q   (ccr_q)
    );

endmodule

// File: rtl/ccr_unit_chk.sv
// Module: ccr_unit_chk
// Port-level temporal checks for ccr_unit, attached by bind.
// Assumes: one-cycle update latency from inputs to ccr_q.
module ccr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_class,
    input logic [15:0] alu_res,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic [7:0]  ccr_q
);
    // R1: reset value one edge after reset is sampled low
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> ccr_q == 8'hD0);

    // R2: full write lands on the next edge
    a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ccr_q == $past(wr_data));

    // R3: control bits hold without a write
    a_r3_masks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (ccr_q[7] == $past(ccr_q[7])) && (ccr_q[6] == $past(ccr_q[6]))
                   && (ccr_q[4] == $past(ccr_q[4])));

    // R4: pass class, unused codes and idle cycles change nothing
    a_r4_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (!op_valid || op_class == 4'd0 || op_class > 4'd10)) |=> $stable(ccr_q));

    // R6: subtract and compare leave H alone
    a_r6_h_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_valid && (op_class == 4'd2 || op_class == 4'd3))
        |=> ccr_q[5] == $past(ccr_q[5]));

    // R7: logic and load/store clear V
    a_r7_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_valid && (op_class == 4'd4 || op_class == 4'd5)) |=> !ccr_q[1]);

    // R10: index step writes only Z, from the full 16 bits
    a_r10_idx_z_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_valid && op_class == 4'd8)
        |=> (ccr_q[7:3] == $past(ccr_q[7:3])) && (ccr_q[1:0] == $past(ccr_q[1:0]))
            && (ccr_q[2] == ($past(alu_res) == 16'h0000)));

endmodule

bind ccr_unit ccr_unit_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_class (op_class),
    .alu_res  (alu_res),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ccr_q    (ccr_q)
);

// File: tb/test_ccr_unit.sv
module test_ccr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_class = 4'd0;
    logic [15:0] alu_res = '0;
    logic        src_a_msb = 1'b0, src_b_msb = 1'b0;
    logic        alu_carry = 1'b0, alu_half = 1'b0, shift_out = 1'b0, md_status = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  ccr_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_ccr;
    bit finished = 0;

    always #5 clk = ~clk;

    ccr_unit i_ccr_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .alu_res(alu_res), .src_a_msb(src_a_msb), .src_b_msb(src_b_msb),
        .alu_carry(alu_carry), .alu_half(alu_half), .shift_out(shift_out),
        .md_status(md_status), .wr_en(wr_en), .wr_data(wr_data), .ccr_q(ccr_q)
    );

    function automatic string tag_of(input logic [3:0] c, input bit wr, input bit vld);
        if (wr) return "R2";
        if (!vld) return "R4";
        case (c)
            4'd1: return "R5";
            4'd2, 4'd3: return "R6";
            4'd4, 4'd5: return "R7";
            4'd6: return "R8";
            4'd7: return "R9";
            4'd8: return "R10";
            4'd9, 4'd10: return "R11";
            default: return "R4";
        endcase
    endfunction

    function automatic int sx8(input logic [7:0] x);
        return x[7] ? int'(x) - 256 : int'(x);
    endfunction

    function automatic int sx16(input logic [15:0] x);
        return x[15] ? int'(x) - 65536 : int'(x);
    endfunction

    task automatic check(input string tag, input logic [7:0] expv);
        checks++;
        if (ccr_q !== expv) begin
            errors++;
            $display("FAIL %s: ccr_q actual %02h expected %02h", tag, ccr_q, expv);
        end
    endtask

    // One operation: drive at negedge, predict, check after the next posedge
    task automatic step(input logic [3:0] c, input logic [15:0] a, input logic [15:0] b,
                        input bit alt, input bit err, input bit vld,
                        input bit wr, input logic [7:0] wd);
        logic [7:0]  e;
        logic [15:0] r;
        int ua, ub, sa, sb, s;
        @(negedge clk);
        e = exp_ccr;
        r = a;
        alu_carry = 1'b0; alu_half = 1'b0; shift_out = 1'b0;
        src_a_msb = a[7]; src_b_msb = b[7];
        ua = int'(a[7:0]); ub = int'(b[7:0]); sa = sx8(a[7:0]); sb = sx8(b[7:0]);
        case (c)
            4'd1: begin
                r = {8'h00, a[7:0] + b[7:0]};
                alu_carry = (ua + ub) > 255; alu_half = (int'(a[3:0]) + int'(b[3:0])) > 15;
                s = sa + sb;
                e[0] = (ua + ub) > 255; e[1] = (s > 127) || (s < -128);
                e[5] = (int'(a[3:0]) + int'(b[3:0])) > 15;
                e[3] = ((ua + ub) % 256) >= 128; e[2] = ((ua + ub) % 256) == 0;
            end
            4'd2, 4'd3: begin
                r = {8'h00, a[7:0] - b[7:0]};
                alu_carry = ua < ub;
                s = sa - sb;
                e[0] = ua < ub; e[1] = (s > 127) || (s < -128);
                e[3] = ((ua - ub + 256) % 256) >= 128; e[2] = ua == ub;
            end
            4'd4: begin
                r = {8'h00, alt ? (a[7:0] | b[7:0]) : (a[7:0] & b[7:0])};
                e[1] = 1'b0; e[3] = r[7]; e[2] = (r[7:0] == 8'h00);
            end
            4'd5: begin
                r = {8'h00, a[7:0]};
                e[1] = 1'b0; e[3] = a[7]; e[2] = (a[7:0] == 8'h00);
            end
            4'd6: begin
                if (alt) begin r = {8'h00, a[6:0], exp_ccr[0]}; shift_out = a[7]; end
                else     begin r = {8'h00, 1'b0, a[7:1]};       shift_out = a[0]; end
                e[0] = shift_out; e[3] = r[7]; e[2] = (r[7:0] == 8'h00);
                e[1] = r[7] ^ shift_out;
            end
            4'd7: begin
                r = 16'(ua * ub);
                e[0] = err; e[2] = (ua * ub) == 0;
            end
            4'd8: begin
                r = alt ? a + 16'd1 : a - 16'd1;
                e[2] = alt ? (a == 16'hFFFF) : (a == 16'h0001);
            end
            4'd9, 4'd10: begin
                src_a_msb = a[15]; src_b_msb = b[15];
                if (c == 4'd9) begin
                    r = a + b; alu_carry = (int'(a) + int'(b)) > 65535;
                    s = sx16(a) + sx16(b);
                    e[0] = (int'(a) + int'(b)) > 65535;
                    e[2] = ((int'(a) + int'(b)) % 65536) == 0;
                    e[3] = ((int'(a) + int'(b)) % 65536) >= 32768;
                end else begin
                    r = a - b; alu_carry = int'(a) < int'(b);
                    s = sx16(a) - sx16(b);
                    e[0] = int'(a) < int'(b);
                    e[2] = a == b;
                    e[3] = ((int'(a) - int'(b) + 65536) % 65536) >= 32768;
                end
                e[1] = (s > 32767) || (s < -32768);
            end
            default: r = a;
        endcase
        if (!vld) e = exp_ccr;
        if (wr) e = wd;
        alu_res = r; md_status = err; op_class = c; op_valid = vld;
        wr_en = wr; wr_data = wd;
        @(posedge clk);
        #1;
        check(tag_of(c, wr, vld), e);
        exp_ccr = ccr_q === e ? e : e;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", 8'hD0);   // R1 reset value
        exp_ccr = 8'hD0;
        @(negedge clk);
        rst_n = 1'b1;

        // R5 directed: overflow, negative, half carry
        step(4'd1, 16'h007F, 16'h0001, 0, 0, 1, 0, 8'h00);
        // R5: carry out, zero, half carry
        step(4'd1, 16'h00FF, 16'h0001, 0, 0, 1, 0, 8'h00);
        // R6: subtract overflow 0x80-0x01
        step(4'd2, 16'h0080, 16'h0001, 0, 0, 1, 0, 8'h00);
        // R6: borrow 0x00-0x01
        step(4'd2, 16'h0000, 16'h0001, 0, 0, 1, 0, 8'h00);
        // R6: compare equal sets Z
        step(4'd3, 16'h0055, 16'h0055, 0, 0, 1, 0, 8'h00);
        // R7: load after an overflow clears V, keeps C
        step(4'd1, 16'h0080, 16'h0080, 0, 0, 1, 0, 8'h00);
        step(4'd5, 16'h0000, 16'h0000, 0, 0, 1, 0, 8'h00);
        // R10: index wrap to zero, then nonzero
        step(4'd8, 16'hFFFF, 16'h0000, 1, 0, 1, 0, 8'h00);
        step(4'd8, 16'h0100, 16'h0000, 0, 0, 1, 0, 8'h00);
        // R9: divide error sets C
        step(4'd7, 16'h0010, 16'h0000, 0, 1, 1, 0, 8'h00);
        // R8: rotate chain through carry
        step(4'd6, 16'h0081, 16'h0000, 1, 0, 1, 0, 8'h00);
        step(4'd6, 16'h0001, 16'h0000, 0, 0, 1, 0, 8'h00);
        // R11: 16-bit add overflow and subtract borrow
        step(4'd9, 16'h7FFF, 16'h0001, 0, 0, 1, 0, 8'h00);
        step(4'd10, 16'h0000, 16'h0001, 0, 0, 1, 0, 8'h00);
        // R4: pass class, unused code, idle cycle
        step(4'd0, 16'h0000, 16'h0000, 0, 0, 1, 0, 8'h00);
        step(4'd13, 16'h0000, 16'h0000, 0, 0, 1, 0, 8'h00);
        step(4'd1, 16'h0000, 16'h0000, 0, 0, 0, 0, 8'h00);
        // R2: write wins over a simultaneous update; R3 masks cleared then held
        step(4'd1, 16'h00FF, 16'h00FF, 0, 0, 1, 1, 8'h00);
        step(4'd1, 16'h00FF, 16'h0001, 0, 0, 1, 0, 8'h00);
        step(4'd2, 16'h0001, 16'h0002, 0, 0, 1, 1, 8'hFF);
        step(4'd8, 16'h0001, 16'h0000, 0, 0, 1, 0, 8'h00);

        // Constrained random mix, R3 covered by every non-write step
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] c;
            bit wr, vld;
            c   = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 11);
            wr  = ($urandom % 16) == 0;
            vld = ($urandom % 8) != 0;
            step(c, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                 vld, wr, 8'($urandom));
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule